// File: doc/BRIEF.md
# DMA Channel Burst Sequencer

This block carries out one DMA channel's transfer cycle as described by a 32-bit channel control word. A pulse on the load input captures the word while the sequencer is idle. The sequencer then raises a bus request toward an external arbiter. Once granted, it issues transfers on a simple request/acknowledge port. Each transfer is one source read followed by one destination write, and each side carries its own three protection attribute bits taken from the word.

The sequencer gives the bus back for rearbitration after a power-of-two number of completed transfers, set by a four-bit exponent field. Exponents of ten or more mean 1024 transfers, so a cycle is never broken up. It also gives the bus back when the cycle runs out of transfers, whichever happens first. At every release it presents an updated copy of the control word in which the count field holds the transfers still outstanding. If transfers remain, it asks for the bus again, and the next grant continues from that count with a fresh burst. After the last transfer it pulses a done flag and falls idle.

Top module: `dma_burst_seq`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in idle: `arb_req`, `bus_held`, `xfer_req`, `arb_release`, `wb_valid` and `cycle_done` are all low in the cycle after any clock edge that sees reset low.
- R2: A `chan_load` pulse seen while idle captures `chan_cfg`, and `arb_req` is high in the next cycle. Bits [13:4] of the word give the transfer total minus one (0 means 1, 10'h3FF means 1024). A `chan_load` seen while not idle is ignored.
- R3: An `arb_gnt` seen while `arb_req` is high makes `bus_held` high and starts a read request in the next cycle. An `arb_gnt` seen while `arb_req` is low has no effect.
- R4: Each transfer is a read request (`xfer_write`=0) followed by a write request (`xfer_write`=1). A request, its direction and its attributes hold until `xfer_ack`, and a transfer completes on the acknowledge of its write.
- R5: Read requests carry word bits [20:18] on `xfer_prot`, and write requests carry bits [23:21]. In both, bit 2 is cacheable, bit 1 is bufferable and bit 0 is privileged.
- R6: The exponent E in bits [17:14] sets the burst length: 2^E transfers for E in 0..9 and 1024 for E in 10..15. A burst ends after that many completed transfers or after the last outstanding one, whichever comes first.
- R7: In the cycle after the write acknowledge that ends a burst, `arb_release` and `wb_valid` pulse high for exactly one cycle, and `bus_held` and `xfer_req` are low.
- R8: While `wb_valid` is high, `wb_word` bits [13:4] hold the outstanding count minus one, and every other bit equals the loaded word.
- R9: After a release with transfers outstanding, `arb_req` is high again. The next grant continues the same cycle with a burst counted from zero, so a cycle of N transfers with burst length L gives ceil(N/L) releases.
- R10: The release that ends the final transfer also pulses `cycle_done` in the same cycle, with `wb_word` bits [13:4] equal to zero, and the sequencer is idle (`arb_req` low) from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_load | input | 1 | Capture `chan_cfg` (taken only while idle) |
| chan_cfg | input | 32 | Channel control word |
| arb_req | output | 1 | Bus wanted from the arbiter |
| arb_gnt | input | 1 | Grant from the arbiter |
| bus_held | output | 1 | Sequencer currently owns the bus |
| arb_release | output | 1 | One-cycle pulse: bus handed back |
| xfer_req | output | 1 | Transfer request valid |
| xfer_write | output | 1 | 0 = source read, 1 = destination write |
| xfer_prot | output | 3 | Protection attributes {cacheable, bufferable, privileged} |
| xfer_ack | input | 1 | Transfer request accepted |
| wb_valid | output | 1 | Updated control word valid |
| wb_word | output | 32 | Updated control word |
| cycle_done | output | 1 | One-cycle pulse: final transfer finished |

## Verification
The end of a burst and the end of the whole cycle can land on the same write acknowledge. This happens when the transfer total is a multiple of the burst length, for example eight transfers with bursts of four, or 1024 transfers with an exponent of 9. The vector table holds several such cycles, next to cycles whose last burst is short. At that single release, the bench checks for one release pulse with `cycle_done` high, a zero count field, no further bus request, and a release total equal to the transfer total divided by the burst length, with no extra empty burst.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_RD   = 2'd2,
      SEQ_WR   = 2'd3
   } seq_state_t;

endpackage

// File: rtl/dma_seq_limit.sv
// Burst length decoder: exponent -> number of transfers per burst.
module dma_seq_limit #(
   parameter int CNT_W = 10,
   parameter int EXP_W = 4
) (
   input  logic [EXP_W-1:0] exp_i,
   output logic [CNT_W:0]   limit_o
);
   localparam int MAX_EXP = CNT_W;
   localparam int ENTRIES = 2 ** EXP_W;

   logic [CNT_W:0] lut [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      if (e >= MAX_EXP) begin : g_sat
         assign lut[e] = (CNT_W+1)'(1) << MAX_EXP;
      end else begin : g_pow
         assign lut[e] = (CNT_W+1)'(1) << e;
      end
   end

   assign limit_o = lut[exp_i];
endmodule

// File: rtl/dma_seq_counter.sv
// Outstanding-transfer and per-burst counters.
module dma_seq_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] nm1_i,
   input  logic             start_i,
   input  logic             step_i,
   input  logic [CNT_W:0]   limit_i,
   output logic [CNT_W:0]   rem_next_o,
   output logic             last_o,
   output logic             burst_end_o
);
   logic [CNT_W:0] rem_q;
   logic [CNT_W:0] burst_q;
   logic [CNT_W:0] burst_next;

   assign rem_next_o  = rem_q - (CNT_W+1)'(1);
   assign burst_next  = burst_q + (CNT_W+1)'(1);
   assign last_o      = (rem_next_o == '0);
   assign burst_end_o = last_o || (burst_next == limit_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         burst_q <= '0;
      end else begin
         if (load_i) begin
            rem_q <= {1'b0, nm1_i} + (CNT_W+1)'(1);
         end else if (step_i) begin
            rem_q <= rem_next_o;
         end
         if (start_i) begin
            burst_q <= '0;
         end else if (step_i) begin
            burst_q <= burst_next;
         end
      end
   end
endmodule

// File: rtl/dma_seq_fsm.sv
// Sequencing of grant, read/write pairs and release.
module dma_seq_fsm
   import dma_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_req_i,
   input  logic       gnt_i,
   input  logic       ack_i,
   input  logic       burst_end_i,
   input  logic       last_i,
   output seq_state_t state_o,
   output logic       load_o,
   output logic       start_o,
   output logic       step_o,
   output logic       rel_o,
   output logic       done_o
);
   seq_state_t st_q;
   logic       rel_q;
   logic       done_q;

   assign state_o = st_q;
   assign load_o  = (st_q == SEQ_IDLE) && load_req_i;
   assign start_o = (st_q == SEQ_WAIT) && gnt_i;
   assign step_o  = (st_q == SEQ_WR) && ack_i;
   assign rel_o   = rel_q;
   assign done_o  = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         rel_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         rel_q  <= 1'b0;
         done_q <= 1'b0;
         case (st_q)
            SEQ_IDLE: if (load_req_i) st_q <= SEQ_WAIT;
            SEQ_WAIT: if (gnt_i) st_q <= SEQ_RD;
            SEQ_RD:   if (ack_i) st_q <= SEQ_WR;
            SEQ_WR: begin
               if (ack_i) begin
                  if (burst_end_i) begin
                     rel_q  <= 1'b1;
                     done_q <= last_i;
                     st_q   <= last_i ? SEQ_IDLE : SEQ_WAIT;
                  end else begin
                     st_q <= SEQ_RD;
                  end
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_seq_word.sv
// Holds the control word and rewrites its count field at each release.
module dma_seq_word #(
   parameter int WORD_W  = 32,
   parameter int CNT_W   = 10,
   parameter int CNT_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] cfg_i,
   input  logic              upd_i,
   input  logic              last_i,
   input  logic [CNT_W:0]    rem_next_i,
   output logic [WORD_W-1:0] word_o
);
   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  field_new;

   assign field_new = last_i ? '0 : CNT_W'(rem_next_i - (CNT_W+1)'(1));
   assign word_o    = word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load_i) begin
         word_q <= cfg_i;
      end else if (upd_i) begin
         word_q[CNT_LSB +: CNT_W] <= field_new;
      end
   end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
   import dma_seq_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int CNT_W        = 10,
   parameter int CNT_LSB      = 4,
   parameter int EXP_W        = 4,
   parameter int EXP_LSB      = 14,
   parameter int PROT_W       = 3,
   parameter int SRC_PROT_LSB = 18,
   parameter int DST_PROT_LSB = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_load,
   input  logic [WORD_W-1:0] chan_cfg,
   output logic              arb_req,
   input  logic              arb_gnt,
   output logic              bus_held,
   output logic              arb_release,
   output logic              xfer_req,
   output logic              xfer_write,
   output logic [PROT_W-1:0] xfer_prot,
   input  logic              xfer_ack,
   output logic              wb_valid,
   output logic [WORD_W-1:0] wb_word,
   output logic              cycle_done
);
   // elaboration-time parameter checks
   if (CNT_LSB + CNT_W > EXP_LSB) begin : g_bad_cnt
      $error("count field overlaps exponent field");
   end
   if (EXP_LSB + EXP_W > SRC_PROT_LSB) begin : g_bad_exp
      $error("exponent field overlaps source attributes");
   end
   if (SRC_PROT_LSB + PROT_W > DST_PROT_LSB) begin : g_bad_src
      $error("source attributes overlap destination attributes");
   end
   if (DST_PROT_LSB + PROT_W > WORD_W) begin : g_bad_dst
      $error("destination attributes exceed word width");
   end

   seq_state_t        st;
   logic              do_load, do_start, do_step;
   logic              burst_end, last;
   logic [CNT_W:0]    limit, rem_next;
   logic [WORD_W-1:0] word;
   logic              rel;

   dma_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_req_i  (chan_load),
      .gnt_i       (arb_gnt),
      .ack_i       (xfer_ack),
      .burst_end_i (burst_end),
      .last_i      (last),
      .state_o     (st),
      .load_o      (do_load),
      .start_o     (do_start),
      .step_o      (do_step),
      .rel_o       (rel),
      .done_o      (cycle_done)
   );

   dma_seq_limit #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_limit (
      .exp_i   (word[EXP_LSB +: EXP_W]),
      .limit_o (limit)
   );

   dma_seq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (do_load),
      .nm1_i       (chan_cfg[CNT_LSB +: CNT_W]),
      .start_i     (do_start),
      .step_i      (do_step),
      .limit_i     (limit),
      .rem_next_o  (rem_next),
      .last_o      (last),
      .burst_end_o (burst_end)
   );

   dma_seq_word #(.WORD_W(WORD_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (do_load),
      .cfg_i      (chan_cfg),
      .upd_i      (do_step && burst_end),
      .last_i     (last),
      .rem_next_i (rem_next),
      .word_o     (word)
   );

   assign arb_req     = (st == SEQ_WAIT);
   assign bus_held    = (st == SEQ_RD) || (st == SEQ_WR);
   assign xfer_req    = bus_held;
   assign xfer_write  = (st == SEQ_WR);
   assign xfer_prot   = xfer_write ? word[DST_PROT_LSB +: PROT_W]
                                   : word[SRC_PROT_LSB +: PROT_W];
   assign arb_release = rel;
   assign wb_valid    = rel;
   assign wb_word     = word;
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
   parameter int WORD_W  = 32,
   parameter int CNT_W   = 10,
   parameter int CNT_LSB = 4,
   parameter int PROT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arb_req,
   input logic              arb_gnt,
   input logic              bus_held,
   input logic              arb_release,
   input logic              xfer_req,
   input logic              xfer_write,
   input logic [PROT_W-1:0] xfer_prot,
   input logic              xfer_ack,
   input logic              wb_valid,
   input logic [WORD_W-1:0] wb_word,
   input logic              cycle_done
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!arb_req && !bus_held && !xfer_req && !arb_release && !cycle_done));

   assert_grant_starts_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_req && arb_gnt) |=> (bus_held && xfer_req && !xfer_write));

   assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_write && xfer_ack) |=> (xfer_req && xfer_write));

   assert_request_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_write) && $stable(xfer_prot)));

   assert_release_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arb_release |=> !arb_release);

   assert_release_frees_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arb_release |-> (wb_valid && !bus_held && !xfer_req));

   assert_done_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |-> (arb_release && (wb_word[CNT_LSB +: CNT_W] == '0) && !arb_req));
endmodule

bind dma_burst_seq dma_burst_seq_chk #(
   .WORD_W(WORD_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB), .PROT_W(PROT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .arb_req(arb_req), .arb_gnt(arb_gnt),
   .bus_held(bus_held), .arb_release(arb_release), .xfer_req(xfer_req),
   .xfer_write(xfer_write), .xfer_prot(xfer_prot), .xfer_ack(xfer_ack),
   .wb_valid(wb_valid), .wb_word(wb_word), .cycle_done(cycle_done)
);

// File: tb/sim_dma_burst_seq.sv
`timescale 1ns/1ps
module sim_dma_burst_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_load = 1'b0;
   logic [31:0] chan_cfg = '0;
   logic        arb_gnt = 1'b0;
   logic        xfer_ack = 1'b0;
   logic        arb_req, bus_held, arb_release, xfer_req, xfer_write;
   logic [2:0]  xfer_prot;
   logic        wb_valid, cycle_done;
   logic [31:0] wb_word;

   always #5 clk = ~clk;

   dma_burst_seq u0 (
      .clk(clk), .rst_n(rst_n), .chan_load(chan_load), .chan_cfg(chan_cfg),
      .arb_req(arb_req), .arb_gnt(arb_gnt), .bus_held(bus_held),
      .arb_release(arb_release), .xfer_req(xfer_req), .xfer_write(xfer_write),
      .xfer_prot(xfer_prot), .xfer_ack(xfer_ack), .wb_valid(wb_valid),
      .wb_word(wb_word), .cycle_done(cycle_done)
   );

   int  n_checks = 0;
   int  n_fail = 0;
   bit  finished = 0;
   int  cycles = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
         finish_run();
      end
   end

   typedef struct packed {
      logic [9:0]  nm1;
      logic [3:0]  ex;
      logic [2:0]  sp;
      logic [2:0]  dp;
      logic [7:0]  hi;
      logic [3:0]  lo;
      logic        stall;
      logic [10:0] exp_rel;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{10'd0,   4'd0,  3'b101, 3'b010, 8'hA5, 4'h3, 1'b0, 11'd1},
      '{10'd4,   4'd1,  3'b011, 3'b100, 8'h5A, 4'hC, 1'b0, 11'd3},
      '{10'd7,   4'd2,  3'b110, 3'b001, 8'hFF, 4'h0, 1'b1, 11'd2},
      '{10'd2,   4'd12, 3'b111, 3'b000, 8'h00, 4'hF, 1'b0, 11'd1},
      '{10'd19,  4'd3,  3'b001, 3'b111, 8'h3C, 4'h9, 1'b1, 11'd3},
      '{10'h3FF, 4'd9,  3'b010, 3'b101, 8'h81, 4'h6, 1'b0, 11'd2},
      '{10'd6,   4'd0,  3'b100, 3'b011, 8'h7E, 4'h1, 1'b1, 11'd7},
      '{10'h3FF, 4'd15, 3'b000, 3'b110, 8'hC3, 4'hA, 1'b0, 11'd1}
   };

   function automatic logic [31:0] mkword(input vec_t v);
      return {v.hi, v.dp, v.sp, v.ex, v.nm1, v.lo};
   endfunction

   task automatic do_load(input logic [31:0] w);
      @(negedge clk);
      chan_cfg  = w;
      chan_load = 1'b1;
      @(negedge clk);
      chan_load = 1'b0;
      chk(arb_req === 1'b1, "R2 request after load", arb_req, 1);
   endtask

   task automatic do_grant();
      while (arb_req !== 1'b1) @(negedge clk);
      arb_gnt = 1'b1;
      @(negedge clk);
      arb_gnt = 1'b0;
      chk(bus_held && xfer_req && !xfer_write, "R3 read after grant",
          {bus_held, xfer_req, xfer_write}, 3'b110);
   endtask

   task automatic serve(input bit stall, input logic [2:0] sp, input logic [2:0] dp,
                        output int n, output logic [31:0] wb, output bit dn);
      bit phase_wr = 0;
      bit tog = 0;
      n = 0;
      forever begin
         if (arb_release === 1'b1) begin
            xfer_ack = 1'b0;
            wb = wb_word;
            dn = cycle_done;
            chk(wb_valid && !bus_held && !xfer_req, "R7 release frees bus",
                {wb_valid, bus_held, xfer_req}, 3'b100);
            @(negedge clk);
            chk(!arb_release, "R7 release is one cycle", arb_release, 0);
            break;
         end
         if (xfer_req === 1'b1) begin
            chk(xfer_write == phase_wr, "R4 read/write order", xfer_write, phase_wr);
            chk(xfer_prot == (phase_wr ? dp : sp), "R5 attributes", xfer_prot,
                phase_wr ? dp : sp);
            tog = !tog;
            if (!stall || tog) begin
               xfer_ack = 1'b1;
               if (phase_wr) n++;
               phase_wr = !phase_wr;
            end else begin
               xfer_ack = 1'b0;
            end
         end else begin
            xfer_ack = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      int n, rem, lim, rel, exp_n;
      logic [31:0] wb, w;
      bit dn;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk({arb_req, bus_held, xfer_req, arb_release, cycle_done, wb_valid} == '0,
          "R1 reset state", {arb_req, bus_held, xfer_req, arb_release, cycle_done}, 0);
      rst_n = 1'b1;

      // R3: grant while idle is ignored
      @(negedge clk);
      arb_gnt = 1'b1;
      @(negedge clk);
      arb_gnt = 1'b0;
      chk(!bus_held && !xfer_req, "R3 grant while idle ignored", {bus_held, xfer_req}, 0);

      // table of vectors: R2 R5 R6 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         w = mkword(VECS[i]);
         do_load(w);
         rem = int'(VECS[i].nm1) + 1;
         lim = (VECS[i].ex >= 10) ? 1024 : (1 << VECS[i].ex);
         rel = 0;
         while (rem > 0 && rel < 1100) begin
            do_grant();
            serve(VECS[i].stall, VECS[i].sp, VECS[i].dp, n, wb, dn);
            rel++;
            exp_n = (rem < lim) ? rem : lim;
            chk(n == exp_n, "R6 burst length", n, exp_n);
            rem = rem - n;
            chk(wb[13:4] == ((rem == 0) ? 10'd0 : 10'(rem - 1)), "R8 count field",
                wb[13:4], (rem == 0) ? 0 : rem - 1);
            chk({wb[31:14], wb[3:0]} == {w[31:14], w[3:0]}, "R8 passthrough bits",
                {wb[31:14], wb[3:0]}, {w[31:14], w[3:0]});
            chk(dn == (rem == 0), "R10 done with final release", dn, rem == 0);
         end
         chk(rel == int'(VECS[i].exp_rel), "R9 release total", rel, VECS[i].exp_rel);
         chk(!arb_req && !bus_held, "R10 idle after done", {arb_req, bus_held}, 0);
      end

      // R2: load while waiting is ignored
      w = {8'h96, 3'b011, 3'b110, 4'd1, 10'd2, 4'h5};
      do_load(w);
      @(negedge clk);
      chan_cfg  = 32'h0F0F_0F0F;
      chan_load = 1'b1;
      @(negedge clk);
      chan_load = 1'b0;
      do_grant();
      serve(1'b0, 3'b110, 3'b011, n, wb, dn);
      chk(n == 2 && wb == {w[31:14], 10'd0, w[3:0]}, "R2 load while busy ignored",
          wb, {w[31:14], 10'd0, w[3:0]});
      do_grant();
      serve(1'b0, 3'b110, 3'b011, n, wb, dn);
      chk(n == 1 && dn, "R9 resume finishes remainder", n, 1);

      // R1: reset in the middle of a burst
      do_load({8'h11, 3'b001, 3'b001, 4'd2, 10'd9, 4'h0});
      do_grant();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk({arb_req, bus_held, xfer_req, arb_release} == '0, "R1 reset mid-burst",
          {arb_req, bus_held, xfer_req, arb_release}, 0);

      finish_run();
   end
endmodule